// File: doc/BRIEF.md
# Bidirectional Saturating Shifter

This block is a single-stage shifter for 32-bit and 64-bit operands whose shift count is a signed 7-bit number. The mode code names a direction. A positive count moves the operand that way, and a negative count moves it the other way by the count's magnitude. A magnitude equal to or beyond the operand width still gives the fully shifted-out result: all zeros, or all copies of the sign bit. Beside the plain arithmetic and logical shifts there is a left shift that clamps to the largest or smallest signed value when the true product does not fit. Two rotates complete the set.

An operation is presented for one cycle with `in_valid`. The result and a one-cycle saturation strobe appear one clock later, qualified by `out_valid`. The strobe is meant to be ORed into a sticky overflow flag elsewhere. With `wide` low, only the low 32 bits of `data` take part, and the 32-bit result is returned sign-extended to 64 bits.

Top module: `bidir_sat_shifter`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `result` and `sat_flag` are cleared to zero.
- R2: An operation accepted with `in_valid` high produces `out_valid` high exactly one cycle later. `out_valid` is low in a cycle that follows a cycle without `in_valid`.
- R3: In the left-named modes (code 0 arithmetic-left, code 1 logical-left) a non-negative count n shifts left and fills with zeros. A count of at least the width gives zero.
- R4: In codes 0 and 1 a negative count shifts right by its magnitude (1 to 64). Code 0 fills with the sign bit and code 1 fills with zeros. A magnitude of at least the width gives all sign bits (code 0) or zero (code 1).
- R5: In the right-named modes (code 2 arithmetic-right, code 3 logical-right) a non-negative count shifts right. Code 2 fills with the sign and code 3 fills with zeros, and counts of at least the width saturate the fill in the same way. A negative count shifts left by its magnitude, giving zero when the magnitude is at least the width.
- R6: In code 4 (saturating left) with a non-negative count, if the operand shifted left does not fit in the signed width, the result is the signed maximum for a non-negative operand or the signed minimum for a negative one. A positive operand that would shift down to exactly zero counts as not fitting.
- R7: In code 4 a zero operand never saturates. A negative count performs an arithmetic right shift without saturation.
- R8: Code 5 rotates left and code 6 rotates right by the count taken modulo the width. A count of zero returns the operand unchanged, and a negative count rotates the opposite way by its magnitude.
- R9: With `wide` low the block operates on `data[31:0]` only, bits 63:32 of `data` have no effect, and `result[63:32]` repeats `result[31]`.
- R10: `sat_flag` is high for exactly the one cycle in which a code-4 result that saturated is presented, and is low otherwise.
- R11: Code 7 is reserved and gives a zero result with `sat_flag` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| mode | input | 3 | Operation code, 0..7 as in the requirements |
| amount | input | 7 | Signed shift or rotate count, -64..63 |
| data | input | 64 | Operand |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 64 | Shifted, rotated or saturated value |
| sat_flag | output | 1 | One-cycle strobe: the saturating shift clamped |

## Verification
The hardest corners are the count of -64 and a magnitude exactly equal to the width. Here the direction is reversed and every operand bit must leave, so the fill decides the whole answer. Another hard corner is the saturating shift that lands on a value that is almost representable. The stimulus walks every count from -64 to 63 through every mode code at both widths. It applies this to a small set of operands chosen to sit on the sign boundary: the most negative value, the most positive value, a single low bit, all ones, and patterns whose upper 32 bits disagree with the narrow sign. Expected values come from a bit-by-bit model and from 128-bit signed arithmetic for the saturation test.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    localparam int BSH_AMT_W  = 7;
    localparam int BSH_MODE_W = 3;

    typedef enum logic [BSH_MODE_W-1:0] {
        BSH_ASL     = 3'd0,
        BSH_LSL     = 3'd1,
        BSH_ASR     = 3'd2,
        BSH_LSR     = 3'd3,
        BSH_ASL_SAT = 3'd4,
        BSH_ROL     = 3'd5,
        BSH_ROR     = 3'd6,
        BSH_RSVD    = 3'd7
    } bsh_mode_e;

    // Decoded count: direction flag and unsigned magnitude (0..64)
    typedef struct packed {
        logic                 neg;
        logic [BSH_AMT_W-1:0] mag;
    } bsh_amt_t;

    function automatic logic bsh_mode_known(bsh_mode_e m);
        return m != BSH_RSVD;
    endfunction

    function automatic logic bsh_is_sat(bsh_mode_e m);
        return m == BSH_ASL_SAT;
    endfunction

endpackage

// File: rtl/bsh_amt_decode.sv
module bsh_amt_decode
    import bsh_pkg::*;
(
    input  logic [BSH_AMT_W-1:0] amount,
    output bsh_amt_t             amt
);
    // Two's complement magnitude; -64 maps to 64 in the unsigned field
    always_comb begin
        amt.neg = amount[BSH_AMT_W-1];
        amt.mag = amt.neg ? (~amount + 1'b1) : amount;
    end
endmodule

// File: rtl/bsh_lane.sv
module bsh_lane
    import bsh_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]         operand,
    input  bsh_amt_t             amt,
    input  logic [$clog2(W)-1:0] rot_amt,
    input  bsh_mode_e            mode,
    output logic [W-1:0]         res,
    output logic                 ovf
);
    localparam int                 RW    = $clog2(W);
    localparam logic [BSH_AMT_W:0] W_EXT = (BSH_AMT_W+1)'(W);

    logic         big;
    logic [W-1:0] up, down_l, down_a, back, rot_l, rot_r, sat_v;
    logic         sat_hit;

    assign big = {1'b0, amt.mag} >= W_EXT;

    // Clamped shifts by the magnitude; direction is chosen per mode below
    assign up     = big ? '0 : (operand << amt.mag);
    assign down_l = big ? '0 : (operand >> amt.mag);
    assign down_a = big ? {W{operand[W-1]}} : W'($signed(operand) >>> amt.mag);

    // Saturation test: a left shift fits when shifting back restores the operand
    assign back    = W'($signed(up) >>> amt.mag);
    assign sat_hit = ~amt.neg & (big ? (|operand) : (back != operand));
    assign sat_v   = operand[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};

    always_comb begin
        if (rot_amt == '0) begin
            rot_l = operand;
            rot_r = operand;
        end else begin
            rot_l = (operand << rot_amt) | (operand >> (W - int'(rot_amt)));
            rot_r = (operand >> rot_amt) | (operand << (W - int'(rot_amt)));
        end
    end

    always_comb begin
        unique case (mode)
            BSH_ASL:     res = amt.neg ? down_a : up;
            BSH_LSL:     res = amt.neg ? down_l : up;
            BSH_ASR:     res = amt.neg ? up : down_a;
            BSH_LSR:     res = amt.neg ? up : down_l;
            BSH_ASL_SAT: res = amt.neg ? down_a : (sat_hit ? sat_v : up);
            BSH_ROL:     res = rot_l;
            BSH_ROR:     res = rot_r;
            default:     res = '0;
        endcase
        ovf = bsh_is_sat(mode) & sat_hit;
    end

    logic unused_rw;
    assign unused_rw = (RW == 0);
endmodule

// File: rtl/bsh_out_reg.sv
module bsh_out_reg #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] d_res,
    input  logic              d_ovf,
    output logic              q_valid,
    output logic [DATA_W-1:0] q_res,
    output logic              q_sat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_res   <= '0;
            q_sat   <= 1'b0;
        end else begin
            q_valid <= in_valid;
            q_sat   <= in_valid & d_ovf;
            if (in_valid) begin
                q_res <= d_res;
            end
        end
    end
endmodule

// File: rtl/bidir_sat_shifter.sv
module bidir_sat_shifter
    import bsh_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic                  wide,
    input  logic [BSH_MODE_W-1:0] mode,
    input  logic [BSH_AMT_W-1:0]  amount,
    input  logic [DATA_W-1:0]     data,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     result,
    output logic                  sat_flag
);
    localparam int HALF_W = DATA_W / 2;

    bsh_mode_e         m;
    bsh_amt_t          dec;
    logic [DATA_W-1:0] lane_out [2];
    logic              lane_ovf [2];
    logic [DATA_W-1:0] sel_res;
    logic              sel_ovf;

    assign m = bsh_mode_e'(mode);

    bsh_amt_decode u_dec (
        .amount (amount),
        .amt    (dec)
    );

    // Lane 0 works on the low half, lane 1 on the full width
    for (genvar g = 0; g < 2; g++) begin : g_lane
        if (g == 0) begin : g_narrow
            logic [HALF_W-1:0] nres;
            bsh_lane #(.W(HALF_W)) u_lane (
                .operand (data[HALF_W-1:0]),
                .amt     (dec),
                .rot_amt (amount[$clog2(HALF_W)-1:0]),
                .mode    (m),
                .res     (nres),
                .ovf     (lane_ovf[g])
            );
            assign lane_out[g] = {{(DATA_W-HALF_W){nres[HALF_W-1]}}, nres};
        end else begin : g_wide
            bsh_lane #(.W(DATA_W)) u_lane (
                .operand (data),
                .amt     (dec),
                .rot_amt (amount[$clog2(DATA_W)-1:0]),
                .mode    (m),
                .res     (lane_out[g]),
                .ovf     (lane_ovf[g])
            );
        end
    end

    assign sel_res = wide ? lane_out[1] : lane_out[0];
    assign sel_ovf = wide ? lane_ovf[1] : lane_ovf[0];

    bsh_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .d_res    (sel_res),
        .d_ovf    (sel_ovf),
        .q_valid  (out_valid),
        .q_res    (result),
        .q_sat    (sat_flag)
    );

    // R2: a valid result is always preceded by an accepted operation
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R9: narrow results are sign-extended from bit 31
    a_r9_narrow_ext: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(wide)) |->
            (result[DATA_W-1:HALF_W] == {(DATA_W-HALF_W){result[HALF_W-1]}}));

    // R6: a saturating result is one of the two signed extremes of its width
    a_r6_sat_extreme: assert property (@(posedge clk) disable iff (rst)
        sat_flag |->
            ($past(wide) ?
                (result == {1'b0, {(DATA_W-1){1'b1}}} || result == {1'b1, {(DATA_W-1){1'b0}}}) :
                (result[HALF_W-1:0] == {1'b0, {(HALF_W-1){1'b1}}} ||
                 result[HALF_W-1:0] == {1'b1, {(HALF_W-1){1'b0}}})));

    // R10: the strobe only follows a saturating-mode operation
    a_r10_sat_mode_only: assert property (@(posedge clk) disable iff (rst)
        sat_flag |-> (out_valid && $past(mode) == BSH_ASL_SAT));

    // R11: the reserved code yields zero and no strobe
    a_r11_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(mode) == BSH_RSVD) |-> (result == '0 && !sat_flag));

    // R8: a zero count in any defined mode returns the operand
    a_r8_zero_count: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(amount == '0 && bsh_mode_known(m))) |->
            (result == $past(wide ? data :
                             {{(DATA_W-HALF_W){data[HALF_W-1]}}, data[HALF_W-1:0]})));
endmodule

// File: tb/bidir_sat_shifter_bench.sv
`timescale 1ns/1ps
module bidir_sat_shifter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        wide = 1'b0;
    logic [2:0]  mode = '0;
    logic [6:0]  amount = '0;
    logic [63:0] data = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        sat_flag;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    bidir_sat_shifter u_bidir_sat_shifter (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .wide      (wide),
        .mode      (mode),
        .amount    (amount),
        .data      (data),
        .out_valid (out_valid),
        .result    (result),
        .sat_flag  (sat_flag)
    );

    function automatic void model(input int md, input bit wd, input logic [63:0] d,
                                  input int a, output logic [63:0] r, output bit s);
        int W, n, k;
        bit arith, left;
        logic fill;
        logic [63:0] t;
        logic signed [127:0] xs, prod, hi, lo;
        W = wd ? 64 : 32;
        n = (a < 0) ? -a : a;
        t = '0;
        s = 1'b0;
        arith = (md == 0 || md == 2 || md == 4);
        fill  = arith ? d[W-1] : 1'b0;
        left  = (md == 0 || md == 1 || md == 4) ? (a >= 0) : (a < 0);
        if (md == 4 && a >= 0) begin
            if (wd) xs = $signed({{64{d[63]}}, d});
            else    xs = $signed({{96{d[31]}}, d[31:0]});
            prod = xs <<< n;
            hi = (128'sd1 <<< (W - 1)) - 128'sd1;
            lo = -hi - 128'sd1;
            if (prod > hi || prod < lo) begin
                s = 1'b1;
                for (int i = 0; i < W; i++) t[i] = (i == W - 1) ? d[W-1] : ~d[W-1];
            end else begin
                t = prod[63:0];
            end
        end else if (md <= 4) begin
            for (int i = 0; i < W; i++) begin
                if (left) t[i] = (i - n >= 0) ? d[i-n] : 1'b0;
                else      t[i] = (i + n < W) ? d[i+n] : fill;
            end
        end else if (md == 5 || md == 6) begin
            k = ((a % W) + W) % W;
            for (int i = 0; i < W; i++)
                t[i] = (md == 5) ? d[(i - k + W) % W] : d[(i + k) % W];
        end
        for (int i = W; i < 64; i++) t[i] = t[W-1];
        r = t;
    endfunction

    function automatic string tag_of(int md, bit wd, int a);
        string t;
        if (md <= 1)      t = (a >= 0) ? "R3" : "R4";
        else if (md <= 3) t = "R5";
        else if (md == 4) t = (a < 0) ? "R7" : "R6";
        else if (md <= 6) t = "R8";
        else              t = "R11";
        if (!wd) t = {t, "/R9"};
        return t;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_case(input int md, input bit wd, input logic [63:0] d, input int a);
        logic [63:0] er;
        bit es;
        model(md, wd, d, a, er, es);
        @(negedge clk);
        in_valid = 1'b1;
        mode     = md[2:0];
        wide     = wd;
        data     = d;
        amount   = a[6:0];
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R2", {63'd0, out_valid}, 64'd1);
        check(result == er, tag_of(md, wd, a), result, er);
        // R10 strobe, and R7 zero operand: no strobe
        check(sat_flag == es, (d == 0) ? "R7/R10" : "R10", {63'd0, sat_flag}, {63'd0, es});
    endtask

    logic [63:0] ops [9];

    initial begin
        ops[0] = 64'h0000_0000_0000_0000;
        ops[1] = 64'h0000_0000_0000_0001;
        ops[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        ops[3] = 64'h8000_0000_0000_0000;
        ops[4] = 64'h7FFF_FFFF_FFFF_FFFF;
        ops[5] = 64'h1234_5678_9ABC_DEF0;
        ops[6] = 64'hA5A5_0000_4000_0001;
        ops[7] = 64'h0000_0001_8000_0000;
        ops[8] = 64'hFFFF_FFFF_3FFF_FFFF;

        repeat (3) @(negedge clk);
        // R1: cleared while reset is held
        check(out_valid == 1'b0, "R1", {63'd0, out_valid}, 64'd0);
        check(result == 64'd0, "R1", result, 64'd0);
        check(sat_flag == 1'b0, "R1", {63'd0, sat_flag}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R2", {63'd0, out_valid}, 64'd0);

        for (int md = 0; md < 8; md++)
            for (int w = 0; w < 2; w++)
                for (int oi = 0; oi < 9; oi++)
                    for (int a = -64; a < 64; a++)
                        run_case(md, w[0], ops[oi], a);

        // R2 and R10: an idle cycle yields no valid and no strobe
        @(negedge clk);
        check(out_valid == 1'b0, "R2", {63'd0, out_valid}, 64'd0);
        check(sat_flag == 1'b0, "R10", {63'd0, sat_flag}, 64'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule